// File: doc/BRIEF.md
# Circular Single-Channel Copy Engine

This block moves data one element at a time from a buffer memory to a peripheral register. Each request pulse from the peripheral starts one transfer. The engine reads a word from the current source pointer, writes it to the current destination pointer, and then steps each pointer that has stepping enabled. It also counts down the number of elements that remain. Software programs start pointers and an element count through a small register port, and then sets the enable bit.

In one-shot mode the engine stops when the count runs out. In wrap-around mode it reloads the count and both pointers from their programmed values and carries on by itself. A half-way flag and an end-of-buffer flag let software refill whichever half of a ring buffer has just drained, while the other half is being consumed. Both flags are sticky, are cleared by writing ones, and each one drives its own masked interrupt line.

Top module: `circ_dma_chan`

## Requirements
- R1: A one-cycle `req` pulse in cycle k, with the engine running and idle, gives an `ack` pulse of exactly one cycle in cycle k+1. Each `ack` moves exactly one element. `ack`, `mem_rd_en` and `per_wr_en` are never high together.
- R2: The cycle after `ack`, `mem_rd_en` is high. The cycle after that, `per_wr_en` is high and `per_wr_data` equals the word the memory returned, one cycle after the read.
- R3: `mem_rd_addr` is the current source pointer and `per_wr_addr` is the current destination pointer. CTRL bit 2 makes the source pointer step by one after each write. CTRL bit 3 does the same for the destination pointer. A pointer whose bit is clear stays fixed.
- R4: With CTRL bit 1 clear, after COUNT writes the remaining count is 0 and no further request is acknowledged.
- R5: With CTRL bit 1 set, the write that leaves 0 remaining reloads the remaining count and both pointers from COUNT, SRC and DST in the same cycle. Transfers then continue.
- R6: STATUS bit 0 (half) is set after the write that leaves floor(COUNT/2) remaining. STATUS bit 1 (end) is set after the write that leaves 0 remaining. Both become visible the cycle after that write.
- R7: A request that arrives while a transfer is in flight is held, one deep, and is acknowledged in the first idle cycle after that transfer.
- R8: Flags stay set until a write of 1 to their STATUS bit. Writing 0 has no effect, and a set in the same cycle wins over a clear. `irq_half` is flag 0 AND CTRL bit 4. `irq_end` is flag 1 AND CTRL bit 5.
- R9: Clearing CTRL bit 0 lets an in-flight transfer finish. After that no request is acknowledged, a pending request is discarded, and the working pointers and count keep their values.
- R10: Enabling with COUNT = 0 produces no acknowledge and no transfer.
- R11: A write that takes CTRL bit 0 from 0 to 1 loads the working pointers and count from SRC, DST and COUNT. The word addresses are 0 CTRL, 1 SRC, 2 DST, 3 COUNT, 4 STATUS, 5 current source, 6 current destination and 7 remaining count. Reads are combinational, and a write takes effect the next cycle.
- R12: After reset every register, flag and output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word address, for both read and write |
| cfg_wdata | input | REG_W | Register write data |
| cfg_rdata | output | REG_W | Register read data, combinational |
| req | input | 1 | Transfer request pulse |
| ack | output | 1 | Request accepted |
| mem_rd_en | output | 1 | Buffer read strobe |
| mem_rd_addr | output | ADDR_W | Buffer read address |
| mem_rd_data | input | DATA_W | Buffer read data, one cycle after the strobe |
| per_wr_en | output | 1 | Peripheral write strobe |
| per_wr_addr | output | ADDR_W | Peripheral write address |
| per_wr_data | output | DATA_W | Peripheral write data |
| irq_half | output | 1 | Masked half-way interrupt |
| irq_end | output | 1 | Masked end-of-buffer interrupt |

## Verification
For a request captured in cycle k, the acknowledge is due in k+1, the read in k+2 and the write in k+3. Flags and the working pointers and count change with that write and can be read in k+4. A held request adds exactly one idle cycle after the write. A register write shows up on reads and interrupt lines one cycle later. The bench steps a behavioural model through the same clock edges. One nanosecond after every falling edge it compares every output, including the register read at a rotating address. No result is sampled at the edge where it is produced.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
   typedef enum logic [1:0] {
      XS_IDLE  = 2'd0,
      XS_READ  = 2'd1,
      XS_WRITE = 2'd2
   } xfer_state_e;

   localparam int unsigned RA_W = 3;
   localparam logic [RA_W-1:0] RA_CTRL   = 3'd0;
   localparam logic [RA_W-1:0] RA_SRC    = 3'd1;
   localparam logic [RA_W-1:0] RA_DST    = 3'd2;
   localparam logic [RA_W-1:0] RA_COUNT  = 3'd3;
   localparam logic [RA_W-1:0] RA_STATUS = 3'd4;
   localparam logic [RA_W-1:0] RA_CSRC   = 3'd5;
   localparam logic [RA_W-1:0] RA_CDST   = 3'd6;
   localparam logic [RA_W-1:0] RA_CCNT   = 3'd7;

   localparam int unsigned CTRL_W = 6;
   localparam int unsigned NFLAG  = 2;
   localparam int unsigned FL_HALF = 0;
   localparam int unsigned FL_END  = 1;

   typedef struct packed {
      logic end_ie;
      logic half_ie;
      logic dst_step;
      logic src_step;
      logic wrap;
      logic en;
   } chan_ctrl_t;
endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
   import dmac_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned REG_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [RA_W-1:0]    cfg_addr,
   input  logic [REG_W-1:0]   cfg_wdata,
   input  logic [ADDR_W-1:0]  cur_src,
   input  logic [ADDR_W-1:0]  cur_dst,
   input  logic [CNT_W-1:0]   cur_cnt,
   input  logic [NFLAG-1:0]   flags,
   output chan_ctrl_t         ctrl,
   output logic [ADDR_W-1:0]  prog_src,
   output logic [ADDR_W-1:0]  prog_dst,
   output logic [CNT_W-1:0]   prog_cnt,
   output logic               start,
   output logic [NFLAG-1:0]   flag_clr,
   output logic [REG_W-1:0]   cfg_rdata
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl     <= '0;
         prog_src <= '0;
         prog_dst <= '0;
         prog_cnt <= '0;
      end else if (cfg_we) begin
         case (cfg_addr)
            RA_CTRL:  ctrl     <= chan_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
            RA_SRC:   prog_src <= cfg_wdata[ADDR_W-1:0];
            RA_DST:   prog_dst <= cfg_wdata[ADDR_W-1:0];
            RA_COUNT: prog_cnt <= cfg_wdata[CNT_W-1:0];
            default:  ;
         endcase
      end
   end

   assign start    = cfg_we && (cfg_addr == RA_CTRL) && cfg_wdata[0] && !ctrl.en;
   assign flag_clr = (cfg_we && (cfg_addr == RA_STATUS)) ? cfg_wdata[NFLAG-1:0] : '0;

   always_comb begin
      case (cfg_addr)
         RA_CTRL:   cfg_rdata = REG_W'(ctrl);
         RA_SRC:    cfg_rdata = REG_W'(prog_src);
         RA_DST:    cfg_rdata = REG_W'(prog_dst);
         RA_COUNT:  cfg_rdata = REG_W'(prog_cnt);
         RA_STATUS: cfg_rdata = REG_W'(flags);
         RA_CSRC:   cfg_rdata = REG_W'(cur_src);
         RA_CDST:   cfg_rdata = REG_W'(cur_dst);
         default:   cfg_rdata = REG_W'(cur_cnt);
      endcase
   end
endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
   import dmac_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DATA_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  chan_ctrl_t         ctrl,
   input  logic               start,
   input  logic [ADDR_W-1:0]  prog_src,
   input  logic [ADDR_W-1:0]  prog_dst,
   input  logic [CNT_W-1:0]   prog_cnt,
   input  logic               req,
   input  logic [DATA_W-1:0]  mem_rd_data,
   output logic               ack,
   output logic               mem_rd_en,
   output logic [ADDR_W-1:0]  mem_rd_addr,
   output logic               per_wr_en,
   output logic [ADDR_W-1:0]  per_wr_addr,
   output logic [DATA_W-1:0]  per_wr_data,
   output logic [ADDR_W-1:0]  cur_src,
   output logic [ADDR_W-1:0]  cur_dst,
   output logic [CNT_W-1:0]   cur_cnt,
   output logic               half_evt,
   output logic               end_evt
);
   localparam int unsigned NPTR = 2;

   xfer_state_e        st_q;
   logic               pend_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [CNT_W-1:0]   cnt_m1;
   logic               running, wr_cyc, last, wrap_now, reload;
   logic [ADDR_W-1:0]  ptr_q  [NPTR];
   logic [ADDR_W-1:0]  base_a [NPTR];
   logic [NPTR-1:0]    step_sel;

   assign running  = ctrl.en && (cnt_q != '0);
   assign ack      = (st_q == XS_IDLE) && running && pend_q;
   assign wr_cyc   = (st_q == XS_WRITE);
   assign cnt_m1   = cnt_q - 1'b1;
   assign last     = wr_cyc && (cnt_m1 == '0);
   assign wrap_now = last && ctrl.wrap;
   assign reload   = start || wrap_now;
   assign half_evt = wr_cyc && (cnt_m1 == (prog_cnt >> 1));
   assign end_evt  = last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= XS_IDLE;
      end else begin
         case (st_q)
            XS_IDLE:  st_q <= ack ? XS_READ : XS_IDLE;
            XS_READ:  st_q <= XS_WRITE;
            default:  st_q <= XS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          pend_q <= 1'b0;
      else if (!ctrl.en)   pend_q <= 1'b0;
      else if (req)        pend_q <= 1'b1;
      else if (ack)        pend_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (reload)  cnt_q <= prog_cnt;
      else if (wr_cyc)  cnt_q <= cnt_m1;
   end

   assign base_a[0] = prog_src;
   assign base_a[1] = prog_dst;
   assign step_sel  = {ctrl.dst_step, ctrl.src_step};

   for (genvar p = 0; p < NPTR; p++) begin : g_ptr
      always_ff @(posedge clk) begin
         if (!rst_n)                      ptr_q[p] <= '0;
         else if (reload)                 ptr_q[p] <= base_a[p];
         else if (wr_cyc && step_sel[p])  ptr_q[p] <= ptr_q[p] + 1'b1;
      end
   end

   assign cur_src     = ptr_q[0];
   assign cur_dst     = ptr_q[1];
   assign cur_cnt     = cnt_q;
   assign mem_rd_en   = (st_q == XS_READ);
   assign mem_rd_addr = ptr_q[0];
   assign per_wr_en   = wr_cyc;
   assign per_wr_addr = ptr_q[1];
   assign per_wr_data = mem_rd_data;

   assert_ack_then_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> mem_rd_en);
   assert_phase_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ack, mem_rd_en, per_wr_en}));
   assert_write_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      per_wr_en |-> $past(mem_rd_en));
   assert_stop_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (last && !ctrl.wrap && !start) |=> (cnt_q == '0) && !ack);
   assert_wrap_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_now && !start) |=> (cnt_q == $past(prog_cnt)) && (ptr_q[0] == $past(prog_src)));
   assert_held_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cyc && pend_q && ctrl.en && !last && !start) |=> ack);
endmodule

// File: rtl/dmac_irq_flags.sv
module dmac_irq_flags
   import dmac_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NFLAG-1:0]  set,
   input  logic [NFLAG-1:0]  clr,
   input  logic [NFLAG-1:0]  ie,
   output logic [NFLAG-1:0]  flags,
   output logic [NFLAG-1:0]  irq
);
   for (genvar f = 0; f < NFLAG; f++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n) flags[f] <= 1'b0;
         else        flags[f] <= set[f] | (flags[f] & ~clr[f]);
      end
      assign irq[f] = flags[f] & ie[f];

      assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[f] && !clr[f]) |=> flags[f]);
      assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
         set[f] |=> flags[f]);
   end
endmodule

// File: rtl/circ_dma_chan.sv
module circ_dma_chan
   import dmac_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned REG_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [2:0]         cfg_addr,
   input  logic [REG_W-1:0]   cfg_wdata,
   output logic [REG_W-1:0]   cfg_rdata,
   input  logic               req,
   output logic               ack,
   output logic               mem_rd_en,
   output logic [ADDR_W-1:0]  mem_rd_addr,
   input  logic [DATA_W-1:0]  mem_rd_data,
   output logic               per_wr_en,
   output logic [ADDR_W-1:0]  per_wr_addr,
   output logic [DATA_W-1:0]  per_wr_data,
   output logic               irq_half,
   output logic               irq_end
);
   if (ADDR_W < 1 || ADDR_W > REG_W) begin : g_bad_addr_w
      $error("ADDR_W must lie in 1..REG_W");
   end
   if (CNT_W < 2 || CNT_W > REG_W) begin : g_bad_cnt_w
      $error("CNT_W must lie in 2..REG_W");
   end
   if (REG_W < CTRL_W) begin : g_bad_reg_w
      $error("REG_W too narrow for the control word");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("DATA_W must be positive");
   end

   chan_ctrl_t         ctrl;
   logic [ADDR_W-1:0]  prog_src, prog_dst, cur_src, cur_dst;
   logic [CNT_W-1:0]   prog_cnt, cur_cnt;
   logic               start, half_evt, end_evt;
   logic [NFLAG-1:0]   flags, flag_clr, flag_set, flag_ie, irq_vec;

   dmac_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cur_src(cur_src), .cur_dst(cur_dst),
      .cur_cnt(cur_cnt), .flags(flags), .ctrl(ctrl), .prog_src(prog_src),
      .prog_dst(prog_dst), .prog_cnt(prog_cnt), .start(start),
      .flag_clr(flag_clr), .cfg_rdata(cfg_rdata)
   );

   dmac_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_engine (
      .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .start(start),
      .prog_src(prog_src), .prog_dst(prog_dst), .prog_cnt(prog_cnt),
      .req(req), .mem_rd_data(mem_rd_data), .ack(ack),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .per_wr_en(per_wr_en), .per_wr_addr(per_wr_addr),
      .per_wr_data(per_wr_data), .cur_src(cur_src), .cur_dst(cur_dst),
      .cur_cnt(cur_cnt), .half_evt(half_evt), .end_evt(end_evt)
   );

   assign flag_set[FL_HALF] = half_evt;
   assign flag_set[FL_END]  = end_evt;
   assign flag_ie[FL_HALF]  = ctrl.half_ie;
   assign flag_ie[FL_END]   = ctrl.end_ie;

   dmac_irq_flags u_flags (
      .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr),
      .ie(flag_ie), .flags(flags), .irq(irq_vec)
   );

   assign irq_half = irq_vec[FL_HALF];
   assign irq_end  = irq_vec[FL_END];

   assert_start_loads_R11: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cur_cnt == $past(prog_cnt)) && (cur_dst == $past(prog_dst)));
   assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.en && !start) |=> !ack);
endmodule

// File: tb/circ_dma_chan_tb_top.sv
module circ_dma_chan_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        req = 1'b0;
   logic        ack, mem_rd_en, per_wr_en, irq_half, irq_end;
   logic [15:0] mem_rd_addr, per_wr_addr;
   logic [31:0] mem_rd_data = '0;
   logic [31:0] per_wr_data;
   logic [31:0] mem_arr [64];

   int vectors = 0;
   int fails   = 0;
   int acks    = 0;
   int rr      = 0;

   bit m_en, m_circ, m_sinc, m_dinc, m_hie, m_eie, m_pend, m_half, m_end;
   int m_src, m_dst, m_cnt, m_csrc, m_cdst, m_ccnt, m_st;

   always #5 clk = ~clk;

   circ_dma_chan dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req(req), .ack(ack),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_rd_data(mem_rd_data), .per_wr_en(per_wr_en),
      .per_wr_addr(per_wr_addr), .per_wr_data(per_wr_data),
      .irq_half(irq_half), .irq_end(irq_end)
   );

   always_ff @(posedge clk) begin
      if (mem_rd_en) mem_rd_data <= mem_arr[mem_rd_addr[5:0]];
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd(int a);
      case (a)
         0: return {26'd0, m_eie, m_hie, m_dinc, m_sinc, m_circ, m_en};
         1: return m_src;
         2: return m_dst;
         3: return m_cnt;
         4: return {30'd0, m_end, m_half};
         5: return m_csrc;
         6: return m_cdst;
         default: return m_ccnt;
      endcase
   endfunction

   function automatic bit exp_ack();
      return (m_st == 0) && m_en && (m_ccnt != 0) && m_pend;
   endfunction

   task automatic compare();
      chk("R1 ack", ack, exp_ack());
      chk("R2 rd_en", mem_rd_en, m_st == 1);
      if (m_st == 1) chk("R3 rd_addr", mem_rd_addr, m_csrc);
      chk("R2 wr_en", per_wr_en, m_st == 2);
      if (m_st == 2) begin
         chk("R3 wr_addr", per_wr_addr, m_cdst);
         chk("R2 wr_data", per_wr_data, mem_arr[m_csrc[5:0]]);
      end
      chk("R8 irq_half", irq_half, m_half && m_hie);
      chk("R8 irq_end", irq_end, m_end && m_eie);
      case (cfg_addr)
         3'd4: chk("R6 status read", cfg_rdata, exp_rd(4));
         3'd7: chk("R4 remaining read", cfg_rdata, exp_rd(7));
         default: chk("R11 register read", cfg_rdata, exp_rd(int'(cfg_addr)));
      endcase
      if (ack) acks++;
   endtask

   task automatic model_step();
      bit c0 = 0, c1 = 0;
      bit st, ak, wr, last, wrap, half;
      int n_ccnt = m_ccnt, n_csrc = m_csrc, n_cdst = m_cdst;
      if (cfg_we && cfg_addr == 3'd4) begin
         c0 = cfg_wdata[0];
         c1 = cfg_wdata[1];
      end
      st   = cfg_we && cfg_addr == 3'd0 && cfg_wdata[0] && !m_en;
      ak   = exp_ack();
      wr   = (m_st == 2);
      last = wr && (m_ccnt == 1);
      wrap = last && m_circ;
      half = wr && ((m_ccnt - 1) == (m_cnt / 2));
      if (st || wrap) begin
         n_ccnt = m_cnt; n_csrc = m_src; n_cdst = m_dst;
      end else if (wr) begin
         n_ccnt = m_ccnt - 1;
         if (m_sinc) n_csrc = (m_csrc + 1) & 16'hFFFF;
         if (m_dinc) n_cdst = (m_cdst + 1) & 16'hFFFF;
      end
      m_pend = !m_en ? 1'b0 : req ? 1'b1 : ak ? 1'b0 : m_pend;
      m_st   = (m_st == 0) ? (ak ? 1 : 0) : (m_st == 1) ? 2 : 0;
      m_half = half || (m_half && !c0);
      m_end  = last || (m_end && !c1);
      m_ccnt = n_ccnt; m_csrc = n_csrc; m_cdst = n_cdst;
      if (cfg_we) begin
         case (cfg_addr)
            3'd0: {m_eie, m_hie, m_dinc, m_sinc, m_circ, m_en} = cfg_wdata[5:0];
            3'd1: m_src = cfg_wdata & 16'hFFFF;
            3'd2: m_dst = cfg_wdata & 16'hFFFF;
            3'd3: m_cnt = cfg_wdata & 16'hFFFF;
            default: ;
         endcase
      end
   endtask

   task automatic tick();
      #1;
      compare();
      @(posedge clk);
      model_step();
      @(negedge clk);
      cfg_we   = 1'b0;
      req      = 1'b0;
      rr       = (rr + 1) % 8;
      cfg_addr = 3'(rr);
   endtask

   task automatic wr_reg(int a, int d);
      cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
      tick();
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic pulse_req();
      req = 1'b1;
      tick();
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      int a0;
      for (int i = 0; i < 64; i++) mem_arr[i] = 32'h1000_0000 + i * 32'h0101_0003;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R12: reset state
      chk("R12 reset ack", ack, 0);
      chk("R12 reset rd_en", mem_rd_en, 0);
      chk("R12 reset wr_en", per_wr_en, 0);
      chk("R12 reset irqs", {irq_half, irq_end}, 0);
      chk("R12 reset ctrl read", cfg_rdata, 0);
      idle(8);

      // One-shot, source stepping: R3 R4 R6 R11
      wr_reg(1, 8); wr_reg(2, 16'h0100); wr_reg(3, 4);
      wr_reg(0, 6'h35);
      a0 = acks;
      for (int i = 0; i < 6; i++) begin pulse_req(); idle(4); end
      chk("R4 one-shot ack total", acks - a0, 4);
      cfg_addr = 3'd4; #1;
      chk("R6 both flags after one-shot", cfg_rdata, 3);
      idle(1);

      // Flag clearing: R8
      wr_reg(4, 0); idle(1);
      wr_reg(4, 1); idle(1);
      cfg_addr = 3'd4; #1;
      chk("R8 write-one clears half only", cfg_rdata, 2);
      idle(1);
      wr_reg(4, 2); idle(2);

      // Wrap-around, both pointers stepping: R5
      wr_reg(0, 0);
      wr_reg(1, 20); wr_reg(2, 16'h0200); wr_reg(3, 3);
      wr_reg(0, 6'h3F);
      a0 = acks;
      for (int i = 0; i < 8; i++) begin pulse_req(); idle(4); end
      chk("R5 wrap ack total", acks - a0, 8);

      // Held request: R7
      a0 = acks;
      pulse_req(); tick(); pulse_req(); idle(6);
      chk("R7 held request serviced", acks - a0, 2);

      // Set beats clear in the same cycle: R8
      wr_reg(4, 3);
      pulse_req(); tick(); tick();
      wr_reg(4, 3); idle(3);

      // Abort mid-transfer: R9
      a0 = acks;
      pulse_req(); tick();
      wr_reg(0, 6'h3E);
      idle(3);
      pulse_req(); idle(4);
      chk("R9 one ack around abort", acks - a0, 1);
      cfg_addr = 3'd7; #1;
      chk("R9 remaining held after abort", cfg_rdata, exp_rd(7));
      idle(1);

      // Fixed pointers: R3
      wr_reg(0, 0);
      wr_reg(1, 40); wr_reg(2, 16'h0300); wr_reg(3, 2);
      wr_reg(0, 6'h01);
      pulse_req(); idle(4); pulse_req(); idle(4);
      wr_reg(0, 0);

      // Zero count: R10
      wr_reg(3, 0);
      wr_reg(0, 6'h07);
      a0 = acks;
      for (int i = 0; i < 3; i++) begin pulse_req(); idle(3); end
      chk("R10 zero count no ack", acks - a0, 0);
      idle(4);

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule